// File: doc/BRIEF.md
# Multi-view inter-thread FIFO cell

This block is one communication cell shared by several hardware threads. Every access names a view. The view picks how the same small circular store and its tag are treated. The raw view peeks at or patches entries without moving the pointers. The tag view reads or rewrites the flags. Two empty/full views push and pop data: one of them stalls the requester when the cell cannot serve it, and the other completes at once.

When a requester asks to wait, the cell records it in a mask of blocked requester IDs and answers with a stall. A later access that does succeed on an empty/full view clears the mask and sends a one-cycle wake pulse to each recorded requester, so those requesters can retry. The semaphore views are recognised but do nothing on a FIFO cell. All responses appear on registered outputs one clock after the access.

Top module: `xtc_fifo_cell`

## Requirements
- R1: After synchronous reset, the count is 0, E=1, F=0, T=0, the FIFO-type flag is 1, the depth-shift field is log2(DEPTH), no requester is blocked, and rsp_valid, rsp_stall, wake_vec and rsp_rdata are all 0.
- R2: The view codes are 0 raw, 1 tag, 2 empty/full wait, 3 empty/full try, 4 semaphore wait and 5 semaphore try. Any other code reads back all ones and changes no state.
- R3: A tag-view read returns a 64-bit word with E at bit 0, F at bit 1, T at bit 16, the FIFO-type flag at bit 17, the entry count starting at bit 18 and the depth shift starting at bit 28. All other bits are 0.
- R4: A tag-view write loads E from data bit 0, F from bit 1 and T from bit 16. When the new E is 1, the count becomes 0.
- R5: A raw-view read returns the entry at the head without popping it. A raw-view write replaces the most recently pushed entry when the count is non-zero, and is ignored when the count is zero.
- R6: An empty/full read clears F. When it is not blocked, it pops the head entry if the count is non-zero and otherwise returns 0. E is set whenever the count is 0 after the access.
- R7: An empty/full write clears E. When it is not blocked, it stores the data at (head+count) mod DEPTH if the count is below DEPTH and otherwise drops the data. F is set whenever the count equals DEPTH after the access.
- R8: A wait-view read while E=1 answers with rsp_stall=1, adds req_id to the blocked mask and does not pop.
- R9: A wait-view write while F=1 answers with rsp_stall=1, adds req_id to the blocked mask and stores nothing.
- R10: An empty/full access that is not blocked drives wake_vec with the blocked mask for exactly one cycle and clears the mask. wake_vec is 0 whenever rsp_stall is 1.
- R11: Semaphore-view accesses read 0 and change no count, flag or entry.
- R12: rsp_valid, rsp_rdata, rsp_stall and wake_vec reflect an access one clock after it is presented. rsp_valid is 0 in cycles that follow no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_view | input | 4 | View code |
| req_wdata | input | 64 | Write data |
| req_id | input | $clog2(NREQ) | Requester ID, used when the access blocks |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | 64 | Read data |
| rsp_stall | output | 1 | The access was blocked and its requester recorded |
| wake_vec | output | NREQ | One-cycle wake pulse per requester |

## Verification
On every cycle the assertions check the following: the count stays within DEPTH; pops and pushes on the try view move the count by exactly one; a flag write that sets E empties the cell; semaphore views leave the state unchanged; a stall comes only from the wait view and never together with a wake; a wake pulse lasts one cycle. Some behaviours can only be shown by the bench's scenarios against its reference model. These are FIFO data order across a wrap, the raw-view overwrite of the newest entry, the ignored raw write on an empty cell (visible only after the head has moved round to the slot it would have hit), dropping of writes to a full cell, the exact tag layout, and which requester bits a wake carries.

// File: rtl/xtc_pkg.sv
package xtc_pkg;
  typedef enum logic [3:0] {
    VW_RAW     = 4'd0,
    VW_TAG     = 4'd1,
    VW_EF_WAIT = 4'd2,
    VW_EF_TRY  = 4'd3,
    VW_PV_WAIT = 4'd4,
    VW_PV_TRY  = 4'd5
  } view_e;

  typedef enum logic [1:0] {
    RS_ZERO,
    RS_ONES,
    RS_MEM,
    RS_TAG
  } rsel_e;

  localparam int TAG_E_BIT     = 0;
  localparam int TAG_F_BIT     = 1;
  localparam int TAG_T_BIT     = 16;
  localparam int TAG_FIFO_BIT  = 17;
  localparam int TAG_CNT_LSB   = 18;
  localparam int TAG_SHIFT_LSB = 28;
endpackage

// File: rtl/xtc_store.sv
module xtc_store #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/xtc_decode.sv
module xtc_decode
  import xtc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          valid,
  input  logic          write,
  input  logic [3:0]    view,
  input  logic          wd_e,
  input  logic          wd_f,
  input  logic          wd_t,
  input  logic [CW-1:0] cnt,
  input  logic [AW-1:0] head,
  input  logic          e,
  input  logic          f,
  input  logic          t,
  output logic [CW-1:0] cnt_n,
  output logic [AW-1:0] head_n,
  output logic          e_n,
  output logic          f_n,
  output logic          t_n,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic          block,
  output logic          wake,
  output rsel_e         rsel
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic waits;
  assign waits = (view == VW_EF_WAIT);

  always_comb begin
    cnt_n     = cnt;
    head_n    = head;
    e_n       = e;
    f_n       = f;
    t_n       = t;
    mem_we    = 1'b0;
    mem_waddr = head + cnt[AW-1:0];
    block     = 1'b0;
    wake      = 1'b0;
    rsel      = RS_ZERO;
    if (valid) begin
      case (view)
        VW_RAW: begin
          if (write) begin
            if (cnt != '0) begin
              mem_we    = 1'b1;
              mem_waddr = head + cnt[AW-1:0] - AW'(1);
            end
          end else begin
            rsel = RS_MEM;
          end
        end
        VW_TAG: begin
          if (write) begin
            e_n = wd_e;
            f_n = wd_f;
            t_n = wd_t;
            if (wd_e) cnt_n = '0;
          end else begin
            rsel = RS_TAG;
          end
        end
        VW_EF_WAIT, VW_EF_TRY: begin
          if (!write) begin
            f_n = 1'b0;
            if (waits && e) begin
              block = 1'b1;
            end else begin
              wake = 1'b1;
              if (cnt != '0) begin
                rsel   = RS_MEM;
                head_n = head + AW'(1);
                cnt_n  = cnt - CW'(1);
              end
              if (cnt_n == '0) e_n = 1'b1;
            end
          end else begin
            e_n = 1'b0;
            if (waits && f) begin
              block = 1'b1;
            end else begin
              wake = 1'b1;
              if (cnt < FULL) begin
                mem_we = 1'b1;
                cnt_n  = cnt + CW'(1);
              end
              if (cnt_n == FULL) f_n = 1'b1;
            end
          end
        end
        VW_PV_WAIT, VW_PV_TRY: rsel = RS_ZERO;
        default: rsel = RS_ONES;
      endcase
    end
  end
endmodule

// File: rtl/xtc_waiters.sv
module xtc_waiters #(
  parameter int NREQ = 4,
  localparam int IW  = $clog2(NREQ)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            block,
  input  logic            wake,
  input  logic [IW-1:0]   id,
  output logic [NREQ-1:0] wake_vec
);
  logic [NREQ-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      wake_vec <= '0;
    end else begin
      wake_vec <= '0;
      if (block) begin
        pend_q <= pend_q | (NREQ'(1) << id);
      end else if (wake) begin
        wake_vec <= pend_q;
        pend_q   <= '0;
      end
    end
  end
endmodule

// File: rtl/xtc_fifo_cell.sv
module xtc_fifo_cell
  import xtc_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NREQ   = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1,
  localparam int IW    = $clog2(NREQ)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [3:0]      req_view,
  input  logic [63:0]     req_wdata,
  input  logic [IW-1:0]   req_id,
  output logic            rsp_valid,
  output logic [63:0]     rsp_rdata,
  output logic            rsp_stall,
  output logic [NREQ-1:0] wake_vec
);
  logic [CW-1:0] cnt_q, cnt_n;
  logic [AW-1:0] head_q, head_n, mem_waddr;
  logic          e_q, f_q, t_q, e_n, f_n, t_n;
  logic          mem_we, block, wake;
  rsel_e         rsel, rsel_q;
  logic [63:0]   tag_w, tag_q, mem_rd;

  always_comb begin
    tag_w = '0;
    tag_w[TAG_E_BIT]              = e_q;
    tag_w[TAG_F_BIT]              = f_q;
    tag_w[TAG_T_BIT]              = t_q;
    tag_w[TAG_FIFO_BIT]           = 1'b1;
    tag_w[TAG_CNT_LSB +: CW]      = cnt_q;
    tag_w[TAG_SHIFT_LSB +: 4]     = 4'(AW);
  end

  xtc_decode #(.DEPTH(DEPTH)) u_dec (
    .valid(req_valid), .write(req_write), .view(req_view),
    .wd_e(req_wdata[TAG_E_BIT]), .wd_f(req_wdata[TAG_F_BIT]), .wd_t(req_wdata[TAG_T_BIT]),
    .cnt(cnt_q), .head(head_q), .e(e_q), .f(f_q), .t(t_q),
    .cnt_n(cnt_n), .head_n(head_n), .e_n(e_n), .f_n(f_n), .t_n(t_n),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .block(block), .wake(wake), .rsel(rsel)
  );

  xtc_store #(.DEPTH(DEPTH), .DATA_W(64)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(req_wdata),
    .raddr(head_q), .rdata(mem_rd)
  );

  xtc_waiters #(.NREQ(NREQ)) u_wait (
    .clk(clk), .rst(rst), .block(block), .wake(wake), .id(req_id), .wake_vec(wake_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      head_q    <= '0;
      e_q       <= 1'b1;
      f_q       <= 1'b0;
      t_q       <= 1'b0;
      rsel_q    <= RS_ZERO;
      tag_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_stall <= 1'b0;
    end else begin
      cnt_q     <= cnt_n;
      head_q    <= head_n;
      e_q       <= e_n;
      f_q       <= f_n;
      t_q       <= t_n;
      rsel_q    <= rsel;
      tag_q     <= tag_w;
      rsp_valid <= req_valid;
      rsp_stall <= block;
    end
  end

  always_comb begin
    case (rsel_q)
      RS_MEM:  rsp_rdata = mem_rd;
      RS_TAG:  rsp_rdata = tag_q;
      RS_ONES: rsp_rdata = '1;
      default: rsp_rdata = '0;
    endcase
  end
endmodule

// File: rtl/xtc_cell_chk.sv
module xtc_cell_chk #(
  parameter int DEPTH = 8,
  parameter int NREQ  = 4,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_write,
  input logic [3:0]      req_view,
  input logic [63:0]     req_wdata,
  input logic            rsp_valid,
  input logic            rsp_stall,
  input logic [NREQ-1:0] wake_vec,
  input logic [CW-1:0]   cnt_q,
  input logic            e_q,
  input logic            f_q
);
  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));

  a_r6_try_pop: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_view == 4'd3 && cnt_q != '0)
      |=> cnt_q == $past(cnt_q) - CW'(1));

  a_r7_try_push: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_view == 4'd3 && cnt_q < CW'(DEPTH))
      |=> cnt_q == $past(cnt_q) + CW'(1));

  a_r4_e_empties: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_view == 4'd1 && req_wdata[0])
      |=> (cnt_q == '0) && e_q);

  a_r11_pv_no_effect: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_view == 4'd4 || req_view == 4'd5))
      |=> $stable(cnt_q) && $stable(e_q) && $stable(f_q));

  a_r8_stall_from_wait_view: assert property (@(posedge clk) disable iff (rst)
    rsp_stall |-> ($past(req_valid) && $past(req_view) == 4'd2));

  a_r10_no_wake_on_stall: assert property (@(posedge clk) disable iff (rst)
    rsp_stall |-> wake_vec == '0);

  a_r10_wake_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (wake_vec != '0) |=> wake_vec == '0);

  a_r12_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
endmodule

bind xtc_fifo_cell xtc_cell_chk #(.DEPTH(DEPTH), .NREQ(NREQ)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_view(req_view), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_stall(rsp_stall), .wake_vec(wake_vec), .cnt_q(cnt_q), .e_q(e_q), .f_q(f_q)
);

// File: tb/xtc_fifo_cell_bench.sv
`timescale 1ns/1ps
module xtc_fifo_cell_bench;
  localparam int D  = 8;
  localparam int NR = 4;
  localparam int IW = $clog2(NR);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]    req_view = '0;
  logic [63:0]   req_wdata = '0;
  logic [IW-1:0] req_id = '0;
  logic          rsp_valid, rsp_stall;
  logic [63:0]   rsp_rdata;
  logic [NR-1:0] wake_vec;

  always #10 clk = ~clk;

  xtc_fifo_cell #(.DEPTH(D), .NREQ(NR)) u_xtc_fifo_cell (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_view(req_view), .req_wdata(req_wdata), .req_id(req_id),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_stall(rsp_stall),
    .wake_vec(wake_vec)
  );

  int checks = 0, fails = 0;
  logic [63:0] mm [D];
  int hd = 0, cnt = 0;
  bit e = 1, f = 0, t = 0;
  bit [NR-1:0] msk = '0;

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] tagval();
    return (64'(3) << 28) | (64'(cnt) << 18) | (64'(1) << 17) |
           (64'(t) << 16) | (64'(f) << 1) | 64'(e);
  endfunction

  task automatic acc(bit wr, bit [3:0] vw, logic [63:0] wd, int id, string rq);
    logic [63:0] er = '0;
    bit es = 0;
    bit [NR-1:0] ew = '0;
    bit blk = (vw == 4'd2);
    case (vw)
      4'd0: if (wr) begin if (cnt > 0) mm[(hd + cnt - 1) % D] = wd; end
            else er = mm[hd];
      4'd1: if (wr) begin t = wd[16]; e = wd[0]; f = wd[1]; if (e) cnt = 0; end
            else er = tagval();
      4'd2, 4'd3: begin
        if (!wr) begin
          f = 0;
          if (blk && e) begin es = 1; msk[id] = 1'b1; end
          else begin
            ew = msk; msk = '0;
            if (cnt > 0) begin er = mm[hd]; hd = (hd + 1) % D; cnt--; end
            if (cnt == 0) e = 1;
          end
        end else begin
          e = 0;
          if (blk && f) begin es = 1; msk[id] = 1'b1; end
          else begin
            ew = msk; msk = '0;
            if (cnt < D) begin mm[(hd + cnt) % D] = wd; cnt++; end
            if (cnt == D) f = 1;
          end
        end
      end
      4'd4, 4'd5: er = '0;
      default: er = '1;
    endcase
    req_valid = 1'b1; req_write = wr; req_view = vw; req_wdata = wd; req_id = IW'(id);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rq, "rsp_valid", 64'(rsp_valid), 64'(1));
    chk(rq, "rsp_stall", 64'(rsp_stall), 64'(es));
    chk(rq, "wake_vec", 64'(wake_vec), 64'(ew));
    if (!wr && !es) chk(rq, "rdata", rsp_rdata, er);
  endtask

  task automatic idle(string rq);
    @(posedge clk);
    @(negedge clk);
    chk(rq, "idle rsp_valid", 64'(rsp_valid), 64'(0));
    chk(rq, "idle wake_vec", 64'(wake_vec), 64'(0));
  endtask

  bit done = 0;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: outputs after reset
    chk("R1", "rsp_valid", 64'(rsp_valid), 0);
    chk("R1", "rsp_stall", 64'(rsp_stall), 0);
    chk("R1", "wake_vec", 64'(wake_vec), 0);
    chk("R1", "rdata", rsp_rdata, 0);
    // R1 R3: reset tag layout
    acc(0, 4'd1, 0, 0, "R1_R3");
    chk("R3", "tag const", tagval(), 64'h0000_0000_3002_0001);
    // R2: undefined views
    acc(0, 4'd7, 0, 0, "R2");
    acc(1, 4'd15, 64'hFFFF, 0, "R2");
    acc(0, 4'd1, 0, 0, "R2");
    // R11: semaphore views on a FIFO cell
    acc(0, 4'd4, 0, 0, "R11");
    acc(1, 4'd5, 64'h55, 0, "R11");
    acc(0, 4'd5, 0, 0, "R11");
    acc(0, 4'd1, 0, 0, "R11");
    // R6: try read of empty cell
    acc(0, 4'd3, 0, 0, "R6");
    // R8: wait read while empty
    acc(0, 4'd2, 0, 2, "R8");
    acc(0, 4'd1, 0, 0, "R8");
    // R10 R7: try write wakes requester 2
    acc(1, 4'd3, 64'hA1, 0, "R10");
    for (int i = 2; i <= 8; i++) acc(1, (i % 2) ? 4'd3 : 4'd2, 64'hA0 + i, 0, "R7");
    acc(0, 4'd1, 0, 0, "R7");
    acc(1, 4'd3, 64'hDEAD, 0, "R7");
    acc(0, 4'd1, 0, 0, "R7");
    // R9: wait write while full
    acc(1, 4'd2, 64'hBEEF, 1, "R9");
    acc(0, 4'd1, 0, 0, "R9");
    // R5: raw peek and overwrite
    acc(0, 4'd0, 0, 0, "R5");
    acc(0, 4'd1, 0, 0, "R5");
    acc(1, 4'd0, 64'hBB, 0, "R5");
    // R6 R10: drain, first pop wakes requester 1
    for (int i = 0; i < 8; i++) acc(0, (i % 2) ? 4'd2 : 4'd3, 0, 0, "R6");
    acc(0, 4'd1, 0, 0, "R6");
    // R5: raw write on empty cell ignored, seen after head wraps
    acc(1, 4'd0, 64'hEE, 0, "R5");
    for (int i = 0; i < 7; i++) acc(1, 4'd3, 64'hC0 + i, 0, "R7");
    for (int i = 0; i < 7; i++) acc(0, 4'd3, 0, 0, "R6");
    acc(0, 4'd0, 0, 0, "R5");
    // R4: tag writes
    acc(1, 4'd3, 64'h11, 0, "R4");
    acc(1, 4'd3, 64'h22, 0, "R4");
    acc(1, 4'd1, (64'(1) << 16) | 64'h2, 0, "R4");
    acc(0, 4'd1, 0, 0, "R4");
    acc(1, 4'd1, 64'h1, 0, "R4");
    acc(0, 4'd1, 0, 0, "R4");
    // R8 R10: two waiters woken together
    acc(0, 4'd2, 0, 3, "R8");
    acc(0, 4'd2, 0, 0, "R8");
    acc(1, 4'd3, 64'h77, 0, "R10");
    acc(0, 4'd3, 0, 0, "R6");
    // R12: no access, no response
    idle("R12");
    finish_run();
  end
endmodule